// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of a single DMA channel. A start strobe loads a channel control word: an operating mode, a transfer count minus one, an arbitration exponent R, a data size code, and source and destination start addresses. A peripheral request or a software request then starts the run. Each transfer reads one item from the source address and writes it to the destination address over a simple request/ready memory handshake. After each transfer, both addresses advance by the data size.

The channel holds the bus in blocks of 2^R transfers. At the end of each block it drops its memory request, which releases the bus. In basic mode it then waits for a fresh request before it continues with the remaining count. In auto-request mode it pauses for one cycle and then resumes by itself. When the full count is done, the channel sets a sticky completion flag and writes its mode back to stop. Only the basic and auto-request modes run. Every other mode code behaves as stop.

Top module: `dma_chan_seq`

## Requirements
- R1: A cycle with `startLoad` high loads the control word and the addresses. The loaded mode is readable on `modeOut`, and no memory access starts until a request arrives.
- R2: In basic (mode 1) or auto-request (mode 2) mode, a cycle in which `periphReq` or `swReq` is high while the channel is idle makes `memReq` high in the next cycle.
- R3: Each transfer is a read (`memWrite`=0) followed by a write (`memWrite`=1). Each completes on a cycle with `memReady` high. The write data equals the data read. While `memReq` is high and `memReady` is low, the address and direction are held.
- R4: The reads use the source address and the writes use the destination address. After each transfer both addresses advance by 1, 2, 4 or 4 bytes for size codes 0, 1, 2 or 3.
- R5: A run performs exactly N = `cfgCountM1` + 1 transfers.
- R6: In basic mode, `memReq` falls after every 2^R transfers. It stays low until a new request arrives, and the run then continues with the remaining count.
- R7: In auto-request mode, at each block boundary `memReq` is low for exactly one cycle, and the run then resumes without a request.
- R8: Exponent values above 10 act as 10, so a block is at most 1024 transfers. If the block size is at least N, the run never suspends.
- R9: When the last transfer completes, `doneFlag` goes high and stays high, and `modeOut` becomes 0 (stop).
- R10: Requests are ignored while the mode is 0 or any of the codes 3 to 7: `memReq` stays low.
- R11: A cycle with `doneClr` high clears `doneFlag`. A clear takes priority over a completion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLoad | input | 1 | Load control word and addresses |
| cfgMode | input | 3 | Mode code (0 stop, 1 basic, 2 auto-request, 3-7 treated as stop) |
| cfgCountM1 | input | CNT_W | Transfer count minus one |
| cfgArbExp | input | ARB_W | Arbitration exponent R |
| cfgSize | input | 2 | Data size code |
| cfgSrcAddr | input | ADDR_W | Source start address |
| cfgDstAddr | input | ADDR_W | Destination start address |
| periphReq | input | 1 | Peripheral transfer request |
| swReq | input | 1 | Software transfer request |
| doneClr | input | 1 | Write-one-to-clear strobe for the completion flag |
| memReq | output | 1 | Memory access request; low means the bus is released |
| memWrite | output | 1 | 1 for write access, 0 for read access |
| memAddr | output | ADDR_W | Access address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data |
| memReady | input | 1 | Access completes in this cycle |
| modeOut | output | 3 | Current mode of the channel |
| doneFlag | output | 1 | Sticky completion flag |

## Verification
The hardest situations to reach from the ports are a block boundary that coincides with a stalled handshake, and a clear that lands in the same cycle as the final write completes. The memory model drops `memReady` at random on every cycle, so block ends arrive behind stalls of varying length. One run holds `doneClr` high for its whole length, so the clear always meets the completion. Runs at the full count of 1024 with exponents of 9 and 12 cover the one-suspension case and the clamped exponent.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    MODE_STOP    = 3'd0,
    MODE_BASIC   = 3'd1,
    MODE_AUTO    = 3'd2,
    MODE_PP      = 3'd3,
    MODE_MSG_PRI = 3'd4,
    MODE_MSG_ALT = 3'd5,
    MODE_PSG_PRI = 3'd6,
    MODE_PSG_ALT = 3'd7
  } chanMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_PAUSE = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic captureRd;
    logic finishXfer;
  } dpCtrl_t;

  function automatic logic [2:0] sizeStep(input logic [1:0] code);
    case (code)
      2'd0:    sizeStep = 3'd1;
      2'd1:    sizeStep = 3'd2;
      default: sizeStep = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10,
  parameter int ARB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [CNT_W-1:0]  cfgCountM1,
  input  logic [ARB_W-1:0]  cfgArbExp,
  input  logic [1:0]        cfgSize,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastXfer,
  output logic              blockEnd
);

  localparam int LEN_W   = CNT_W + 1;
  localparam int MAX_EXP = CNT_W;

  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] blkCnt;
  logic [LEN_W-1:0] blkLimit;
  logic [2:0]       step;
  logic [ARB_W-1:0] effExp;

  always_comb begin
    effExp = (cfgArbExp > ARB_W'(MAX_EXP)) ? ARB_W'(MAX_EXP) : cfgArbExp;
  end

  assign lastXfer = (remaining == LEN_W'(1));
  assign blockEnd = ((blkCnt + LEN_W'(1)) == blkLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      wrData    <= '0;
      remaining <= '0;
      blkCnt    <= '0;
      blkLimit  <= LEN_W'(1);
      step      <= 3'd1;
    end else if (ctl.loadCfg) begin
      srcAddr   <= cfgSrcAddr;
      dstAddr   <= cfgDstAddr;
      remaining <= LEN_W'(cfgCountM1) + LEN_W'(1);
      blkCnt    <= '0;
      blkLimit  <= LEN_W'(1) << effExp;
      step      <= sizeStep(cfgSize);
    end else begin
      if (ctl.captureRd) wrData <= memRdata;
      if (ctl.finishXfer) begin
        srcAddr   <= srcAddr + ADDR_W'(step);
        dstAddr   <= dstAddr + ADDR_W'(step);
        remaining <= remaining - LEN_W'(1);
        blkCnt    <= blockEnd ? '0 : blkCnt + LEN_W'(1);
      end
    end
  end

  // R8
  blk_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkCnt < blkLimit);

  // R5
  remain_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishXfer |-> remaining != '0);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startLoad,
  input  logic [2:0] cfgMode,
  input  logic       periphReq,
  input  logic       swReq,
  input  logic       doneClr,
  input  logic       memReady,
  input  logic       lastXfer,
  input  logic       blockEnd,
  output dpCtrl_t    ctl,
  output logic       memReq,
  output logic       memWrite,
  output logic [2:0] modeOut,
  output logic       doneFlag
);

  seqState_e state, nextState;
  chanMode_e modeReg;
  logic      runnable;
  logic      setDone;

  assign runnable = (modeReg == MODE_BASIC) || (modeReg == MODE_AUTO);
  assign memReq   = (state == ST_READ) || (state == ST_WRITE);
  assign memWrite = (state == ST_WRITE);
  assign modeOut  = modeReg;

  always_comb begin
    nextState      = state;
    ctl            = '0;
    ctl.loadCfg    = startLoad;
    setDone        = 1'b0;
    if (startLoad) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (runnable && (periphReq || swReq)) nextState = ST_READ;
        ST_READ: if (memReady) begin
          ctl.captureRd = 1'b1;
          nextState     = ST_WRITE;
        end
        ST_WRITE: if (memReady) begin
          ctl.finishXfer = 1'b1;
          if (lastXfer) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
          end else if (blockEnd) begin
            nextState = (modeReg == MODE_AUTO) ? ST_PAUSE : ST_IDLE;
          end else begin
            nextState = ST_READ;
          end
        end
        default: nextState = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeReg  <= MODE_STOP;
      doneFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (startLoad)    modeReg <= chanMode_e'(cfgMode);
      else if (setDone) modeReg <= MODE_STOP;
      if (doneClr)      doneFlag <= 1'b0;
      else if (setDone) doneFlag <= 1'b1;
    end
  end

  // R7
  pause_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSE && !startLoad) |=> memReq && !memWrite);

  // R10
  stopped_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !runnable) |=> !memReq);

  // R6
  idle_waits_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !periphReq && !swReq) |=> !memReq);

  // R11
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneClr |=> !doneFlag);

  // R3
  hold_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !startLoad) |=> memReq && $stable(memWrite));

  // R9
  done_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> modeOut == MODE_STOP);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10,
  parameter int ARB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startLoad,
  input  logic [2:0]        cfgMode,
  input  logic [CNT_W-1:0]  cfgCountM1,
  input  logic [ARB_W-1:0]  cfgArbExp,
  input  logic [1:0]        cfgSize,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic              periphReq,
  input  logic              swReq,
  input  logic              doneClr,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic [2:0]        modeOut,
  output logic              doneFlag
);

  dpCtrl_t           ctl;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic              lastXfer;
  logic              blockEnd;

  dma_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startLoad (startLoad),
    .cfgMode   (cfgMode),
    .periphReq (periphReq),
    .swReq     (swReq),
    .doneClr   (doneClr),
    .memReady  (memReady),
    .lastXfer  (lastXfer),
    .blockEnd  (blockEnd),
    .ctl       (ctl),
    .memReq    (memReq),
    .memWrite  (memWrite),
    .modeOut   (modeOut),
    .doneFlag  (doneFlag)
  );

  dma_seq_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ARB_W  (ARB_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgCountM1 (cfgCountM1),
    .cfgArbExp  (cfgArbExp),
    .cfgSize    (cfgSize),
    .cfgSrcAddr (cfgSrcAddr),
    .cfgDstAddr (cfgDstAddr),
    .memRdata   (memRdata),
    .srcAddr    (srcAddr),
    .dstAddr    (dstAddr),
    .wrData     (memWdata),
    .lastXfer   (lastXfer),
    .blockEnd   (blockEnd)
  );

  assign memAddr = memWrite ? dstAddr : srcAddr;

endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startLoad = 1'b0;
  logic [2:0]  cfgMode = '0;
  logic [9:0]  cfgCountM1 = '0;
  logic [3:0]  cfgArbExp = '0;
  logic [1:0]  cfgSize = '0;
  logic [31:0] cfgSrcAddr = '0;
  logic [31:0] cfgDstAddr = '0;
  logic        periphReq = 1'b0;
  logic        swReq = 1'b0;
  logic        doneClr = 1'b0;
  logic        memReq, memWrite, doneFlag;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memReady = 1'b0;
  logic [2:0]  modeOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // monitor state
  bit          monActive = 0;
  bit          reqSeen = 0;
  bit          curAuto = 0;
  bit          prevReq = 0;
  bit          prevStall = 0;
  bit          inGap = 0;
  int          gapLen = 0;
  int          xferCnt = 0;
  int          suspCnt = 0;
  int          expN = 0;
  int          expBlk = 1;
  logic [31:0] expSrc, expDst, rdVal, prevAddr;
  logic [31:0] stepVal = 1;

  always #10 clk = ~clk;

  function automatic logic [31:0] expData(input logic [31:0] a);
    return (a ^ 32'h5A5A_0F0F) + 32'd17;
  endfunction

  function automatic logic [31:0] stepOf(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic int blkOf(input int r);
    return 1 << ((r > 10) ? 10 : r);
  endfunction

  function automatic int expSusp(input int n, input int blk);
    return (n + blk - 1) / blk - 1;
  endfunction

  assign memRdata = expData(memAddr);

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .cfgMode(cfgMode),
    .cfgCountM1(cfgCountM1), .cfgArbExp(cfgArbExp), .cfgSize(cfgSize),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr), .periphReq(periphReq),
    .swReq(swReq), .doneClr(doneClr), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .modeOut(modeOut), .doneFlag(doneFlag)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model and transfer monitor
  always @(negedge clk) begin
    if (!rstN) begin
      memReady = 1'b0;
      prevReq = 0;
      prevStall = 0;
    end else begin
      if (prevStall)
        check(memReq && memAddr == prevAddr, "R3 held during stall", memAddr, prevAddr);
      memReady = ($urandom % 3) != 0;
      if (memReq) reqSeen = 1;
      if (monActive) begin
        if (memReq && memReady) begin
          if (!memWrite) begin
            check(memAddr == expSrc, "R4 read address", memAddr, expSrc);
            rdVal = expData(memAddr);
          end else begin
            check(memAddr == expDst, "R4 write address", memAddr, expDst);
            check(memWdata == rdVal, "R3 write data", memWdata, rdVal);
            xferCnt++;
            expSrc = expSrc + stepVal;
            expDst = expDst + stepVal;
          end
        end
        if (prevReq && !memReq && xferCnt < expN) begin
          suspCnt++;
          check((xferCnt % expBlk) == 0, "R6 suspension point", xferCnt, expBlk);
          inGap = 1;
          gapLen = 0;
        end
        if (!memReq && inGap) gapLen++;
        if (!prevReq && memReq && inGap) begin
          if (curAuto) check(gapLen == 1, "R7 pause length", gapLen, 1);
          inGap = 0;
        end
      end
      prevStall = memReq && !memReady;
      prevAddr = memAddr;
      prevReq = memReq;
    end
  end

  task automatic reqPulse(input bit usePeriph);
    @(negedge clk);
    if (usePeriph) periphReq = 1'b1; else swReq = 1'b1;
    @(negedge clk);
    periphReq = 1'b0;
    swReq = 1'b0;
  endtask

  task automatic loadCfg(input int mode, input int n, input int r, input int size,
                         input logic [31:0] src, input logic [31:0] dst);
    @(negedge clk);
    startLoad = 1'b1;
    cfgMode = 3'(mode);
    cfgCountM1 = 10'(n - 1);
    cfgArbExp = 4'(r);
    cfgSize = 2'(size);
    cfgSrcAddr = src;
    cfgDstAddr = dst;
    @(negedge clk);
    startLoad = 1'b0;
  endtask

  task automatic runTest(input int mode, input int n, input int r, input int size,
                         input logic [31:0] src, input logic [31:0] dst,
                         input bit holdClr);
    int guard;
    int cyc;
    bit ok;
    expN = n; expBlk = blkOf(r); stepVal = stepOf(size);
    expSrc = src; expDst = dst; curAuto = (mode == 2);
    xferCnt = 0; suspCnt = 0; inGap = 0;
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
    loadCfg(mode, n, r, size, src, dst);
    monActive = 1; reqSeen = 0;
    repeat (3) @(negedge clk);
    // R1: loaded mode visible, no access without request
    check(!reqSeen && modeOut == 3'(mode), "R1 load without start", {28'd0, reqSeen, modeOut}, mode);
    if (holdClr) doneClr = 1'b1;
    guard = 0; cyc = 0;
    if (mode == 1) begin
      while (xferCnt < n && guard < 1100 && cyc < 60000) begin
        reqPulse(guard[0]);
        check(memReq, "R2 start after request", memReq, 1);
        while (memReq && cyc < 60000) begin @(negedge clk); cyc++; end
        if (xferCnt < n) begin
          ok = 1;
          repeat (5) begin @(negedge clk); if (memReq) ok = 0; end
          check(ok, "R6 released until new request", ok, 1);
        end
        guard++;
      end
    end else begin
      reqPulse(1'b0);
      check(memReq, "R2 start after request", memReq, 1);
      while (!(xferCnt == n && !memReq) && cyc < 60000) begin @(negedge clk); cyc++; end
    end
    @(negedge clk);
    check(xferCnt == n, "R5 transfer count", xferCnt, n);
    check(suspCnt == expSusp(n, expBlk), "R8 suspension count", suspCnt, expSusp(n, expBlk));
    check(modeOut == 3'd0, "R9 mode back to stop", modeOut, 0);
    if (holdClr) check(!doneFlag, "R11 clear beats set", doneFlag, 0);
    else         check(doneFlag, "R9 completion flag", doneFlag, 1);
    doneClr = 1'b0;
    monActive = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!memReq && !doneFlag && modeOut == 0, "R1 reset state", {memReq, doneFlag, modeOut}, 0);

    runTest(1, 8, 1, 2, 32'h0000_1000, 32'h0000_2000, 0);   // R6 basic blocks of 2
    runTest(2, 8, 1, 1, 32'h0000_3000, 32'h0000_4002, 0);   // R7 auto blocks of 2
    runTest(2, 5, 3, 0, 32'h0000_5001, 32'h0000_6003, 0);   // R8 block larger than N
    runTest(1, 1, 0, 3, 32'hFFFF_FFFC, 32'h0000_0010, 0);   // R4 size code 3, wrap
    runTest(2, 7, 0, 0, 32'h0000_7000, 32'h0000_8000, 0);   // R7 pause after every transfer

    // R9 flag stays set while idle
    repeat (4) @(negedge clk);
    check(doneFlag, "R9 flag sticky", doneFlag, 1);
    // R11 plain clear
    doneClr = 1'b1; @(negedge clk); doneClr = 1'b0;
    check(!doneFlag, "R11 clear strobe", doneFlag, 0);

    // R10 requests while stopped after completion
    reqSeen = 0;
    periphReq = 1'b1; swReq = 1'b1;
    repeat (4) @(negedge clk);
    periphReq = 1'b0; swReq = 1'b0;
    @(negedge clk);
    check(!reqSeen, "R10 request ignored when stopped", reqSeen, 0);

    // R10 unsupported codes behave as stop
    for (int m = 3; m < 8; m++) begin
      loadCfg(m, 4, 1, 2, 32'h100, 32'h200);
      reqSeen = 0;
      periphReq = 1'b1; swReq = 1'b1;
      repeat (3) @(negedge clk);
      periphReq = 1'b0; swReq = 1'b0;
      @(negedge clk);
      check(!reqSeen, "R10 unsupported mode ignored", reqSeen, 0);
    end

    runTest(1, 4, 2, 2, 32'h0000_9000, 32'h0000_A000, 1);   // R11 held clear
    runTest(2, 1024, 12, 2, 32'h0001_0000, 32'h0002_0000, 0); // R8 clamped exponent
    runTest(1, 1024, 9, 1, 32'h0003_0000, 32'h0004_0000, 0);  // R8 one suspension

    for (int i = 0; i < 10; i++) begin
      runTest(1 + int'($urandom % 2), 1 + int'($urandom % 40), int'($urandom % 7),
              int'($urandom % 4), $urandom, $urandom, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule